// File: doc/BRIEF.md
# Priority Interrupt Controller Hub

The hub sits between four shared interrupt request lines and a processor that accepts one interrupt signal and answers with one acknowledge. Each request line stands for one hardware priority level, 4 up to 7, and is pulled low by any device on that level that wants service. The hub passes the request lines through a synchronizer. It then compares each active level with the processor's 3-bit execution priority and with its interrupt-enable bit, and raises a registered interrupt output while at least one level is eligible.

When the processor raises its acknowledge, the hub latches the highest eligible level. It drives the active-high acknowledge line of that level until the processor drops its acknowledge, and reports the serviced level number. Request lines may change while the acknowledge is held; the routing stays fixed until the acknowledge falls.

Top module: `prio_irq_hub`

## Requirements
- R1: After reset, `intReq` is 0, `ackLines` is 0 and `svcLevel` is 0.
- R2: A request line going low with an eligible level raises `intReq` on the third rising clock edge after the change: two edges for the synchronizer and one for the output register.
- R3: Level L (bit index L-4 of `reqLinesN` and `ackLines`) is eligible only when L is strictly greater than `cpuPrio`. A level equal to or below `cpuPrio` never raises `intReq` and is never acknowledged.
- R4: While `irqEnable` is 0, no level is eligible, and `intReq` is 0 from the first edge after `irqEnable` falls.
- R5: `intReq` falls on the first edge after the last eligible level stops being eligible. For a released request line that is the third edge after the release, and for a priority or enable change it is the first edge after the change.
- R6: On the first edge where `cpuAck` is 1 after being 0, the hub latches the highest eligible level. From that edge on, it drives only that level's acknowledge line (bit index level-4) and puts the level number on `svcLevel`.
- R7: While `cpuAck` stays 1, `ackLines` and `svcLevel` hold their latched values whatever the request lines, `cpuPrio` or `irqEnable` do.
- R8: On the first edge with `cpuAck` at 0, `ackLines` and `svcLevel` return to 0.
- R9: If no level is eligible on the edge where `cpuAck` rises, no acknowledge line is driven and `svcLevel` stays 0 for the whole acknowledge.
- R10: At most one bit of `ackLines` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqLinesN | input | 4 | Active-low request lines; bit i is level 4+i |
| cpuPrio | input | 3 | Processor execution priority |
| irqEnable | input | 1 | Processor interrupt-enable bit |
| cpuAck | input | 1 | Processor acknowledge, active high |
| intReq | output | 1 | Registered interrupt to the processor |
| ackLines | output | 4 | Active-high per-level acknowledges; bit i is level 4+i |
| svcLevel | output | 3 | Level being acknowledged, 0 when none |

## Verification
The bench builds the hub with its defaults: four levels based at 4, a 3-bit priority and a two-stage synchronizer. At these values every execution priority from 0 to 7 can be driven, so the strict comparison is reached at its edges. These include priority 3, which admits all levels, priority 7, which admits none, and each equality case. The exact synchronizer depth also makes the three-edge request latency and release latency checkable cycle by cycle.

// File: rtl/hub_pkg.sv
package hub_pkg;
  typedef struct packed {
    logic latchStb;
    logic clearStb;
  } hubStrobes_t;
endpackage

// File: rtl/hub_sync.sv
module hub_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= {WIDTH{RST_VAL}};
          else       stage[s] <= dIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= {WIDTH{RST_VAL}};
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];
endmodule

// File: rtl/hub_control.sv
module hub_control
  import hub_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuAck,
  input  logic        anyEligible,
  output hubStrobes_t ctl,
  output logic        intReq
);
  logic ackPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPrev <= 1'b0;
      intReq  <= 1'b0;
    end else begin
      ackPrev <= cpuAck;
      intReq  <= anyEligible;
    end
  end

  always_comb begin
    ctl.latchStb = cpuAck && !ackPrev;
    ctl.clearStb = !cpuAck;
  end

  // R5: interrupt drops one edge after eligibility ends
  assert_int_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    !anyEligible |=> !intReq);

  // strobes never both active
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.latchStb && ctl.clearStb));
endmodule

// File: rtl/hub_datapath.sv
module hub_datapath
  import hub_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int BASE_LEVEL = 4,
  parameter int PRIO_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] reqSyncN,
  input  logic [PRIO_W-1:0]     cpuPrio,
  input  logic                  irqEnable,
  input  hubStrobes_t           ctl,
  output logic                  anyEligible,
  output logic [NUM_LEVELS-1:0] ackLines,
  output logic [PRIO_W-1:0]     svcLevel
);
  localparam int IDX_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1;

  logic [NUM_LEVELS-1:0] eligible;
  logic [IDX_W-1:0]      topIdx;
  logic                  svcValid;
  logic [IDX_W-1:0]      svcIdx;

  generate
    for (genvar i = 0; i < NUM_LEVELS; i++) begin : gElig
      always_comb begin
        eligible[i] = irqEnable && !reqSyncN[i] && (int'(cpuPrio) < BASE_LEVEL + i);
      end
    end
  endgenerate

  always_comb begin
    topIdx = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (eligible[i]) topIdx = IDX_W'(i);
    end
  end

  assign anyEligible = |eligible;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcValid <= 1'b0;
      svcIdx   <= '0;
    end else if (ctl.clearStb) begin
      svcValid <= 1'b0;
      svcIdx   <= '0;
    end else if (ctl.latchStb) begin
      svcValid <= anyEligible;
      svcIdx   <= topIdx;
    end
  end

  always_comb begin
    ackLines = '0;
    svcLevel = '0;
    if (svcValid) begin
      ackLines[svcIdx] = 1'b1;
      svcLevel = PRIO_W'(BASE_LEVEL + int'(svcIdx));
    end
  end

  // R3: a latched level is strictly above the priority seen at latch time
  assert_strict_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latchStb && anyEligible) |=> (int'(svcLevel) > int'($past(cpuPrio))));

  // R9: latching with nothing eligible grants nothing
  assert_empty_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latchStb && !anyEligible) |=> (ackLines == '0));

  // R10: one acknowledge at most
  assert_one_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackLines));
endmodule

// File: rtl/prio_irq_hub.sv
module prio_irq_hub
  import hub_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  parameter int BASE_LEVEL = 4,
  parameter int PRIO_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] reqLinesN,
  input  logic [PRIO_W-1:0]     cpuPrio,
  input  logic                  irqEnable,
  input  logic                  cpuAck,
  output logic                  intReq,
  output logic [NUM_LEVELS-1:0] ackLines,
  output logic [PRIO_W-1:0]     svcLevel
);
  logic [NUM_LEVELS-1:0] reqSyncN;
  logic                  anyEligible;
  hubStrobes_t           ctl;

  hub_sync #(.WIDTH(NUM_LEVELS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSync (
    .clk(clk), .rstN(rstN), .dIn(reqLinesN), .dOut(reqSyncN)
  );

  hub_datapath #(.NUM_LEVELS(NUM_LEVELS), .BASE_LEVEL(BASE_LEVEL), .PRIO_W(PRIO_W)) uData (
    .clk(clk), .rstN(rstN), .reqSyncN(reqSyncN), .cpuPrio(cpuPrio),
    .irqEnable(irqEnable), .ctl(ctl), .anyEligible(anyEligible),
    .ackLines(ackLines), .svcLevel(svcLevel)
  );

  hub_control uCtrl (
    .clk(clk), .rstN(rstN), .cpuAck(cpuAck), .anyEligible(anyEligible),
    .ctl(ctl), .intReq(intReq)
  );

  // R4: disabled interrupts keep the output low
  assert_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |=> !intReq);

  // R7: routing holds while acknowledge is held
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAck && ackLines != '0) |=> (!cpuAck || ($stable(ackLines) && $stable(svcLevel))));

  // R8: acknowledge low clears routing
  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cpuAck |=> (ackLines == '0 && svcLevel == '0));
endmodule

// File: tb/prio_irq_hub_test.sv
module prio_irq_hub_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] reqLinesN = 4'hF;
  logic [2:0] cpuPrio = 3'd0;
  logic       irqEnable = 1'b0;
  logic       cpuAck = 1'b0;
  logic       intReq;
  logic [3:0] ackLines;
  logic [2:0] svcLevel;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  prio_irq_hub uut (
    .clk(clk), .rstN(rstN), .reqLinesN(reqLinesN), .cpuPrio(cpuPrio),
    .irqEnable(irqEnable), .cpuAck(cpuAck), .intReq(intReq),
    .ackLines(ackLines), .svcLevel(svcLevel)
  );

  // expected: highest eligible level, 0 if none
  function automatic int expLevel(logic [3:0] req, logic [2:0] prio, logic en);
    int lvl = 0;
    for (int i = 0; i < 4; i++)
      if (en && !req[i] && (4 + i > int'(prio))) lvl = 4 + i;
    return lvl;
  endfunction

  function automatic logic [3:0] expAck(int lvl);
    return (lvl >= 4) ? (4'b0001 << (lvl - 4)) : 4'b0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lvl;
    logic [3:0] r;
    logic [2:0] p;
    logic e;
    logic [3:0] heldAck;
    logic [2:0] heldLvl;
    void'($urandom(32'd1234));

    edges(3);
    look();
    chk(intReq == 1'b0, "R1 intReq", intReq, 0);
    chk(ackLines == 4'b0, "R1 ackLines", ackLines, 0);
    chk(svcLevel == 3'd0, "R1 svcLevel", svcLevel, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    irqEnable = 1'b1;
    edges(2);

    // R2: latency of three edges, level 5 (bit 1)
    reqLinesN = 4'b1101;
    edges(2); look();
    chk(intReq == 1'b0, "R2 before third edge", intReq, 0);
    @(posedge clk); #1; look();
    chk(intReq == 1'b1, "R2 third edge", intReq, 1);

    // R5: release latency
    @(posedge clk); #1;
    reqLinesN = 4'b1111;
    edges(2); look();
    chk(intReq == 1'b1, "R5 still high before third edge", intReq, 1);
    @(posedge clk); #1; look();
    chk(intReq == 1'b0, "R5 low on third edge", intReq, 0);

    // R3: equal priority is not eligible
    @(posedge clk); #1;
    reqLinesN = 4'b1101; cpuPrio = 3'd5;
    edges(4); look();
    chk(intReq == 1'b0, "R3 level5 at prio5", intReq, 0);
    @(posedge clk); #1;
    cpuPrio = 3'd4;
    edges(1); look();
    chk(intReq == 1'b1, "R3 level5 at prio4", intReq, 1);
    @(posedge clk); #1;
    cpuPrio = 3'd5;
    edges(1); look();
    chk(intReq == 1'b0, "R5 prio raise drops in one edge", intReq, 0);

    // R4: enable off
    @(posedge clk); #1;
    cpuPrio = 3'd0; reqLinesN = 4'b0000;
    edges(4); look();
    chk(intReq == 1'b1, "R4 enabled all", intReq, 1);
    @(posedge clk); #1;
    irqEnable = 1'b0;
    edges(1); look();
    chk(intReq == 1'b0, "R4 disabled", intReq, 0);
    @(posedge clk); #1;
    irqEnable = 1'b1;

    // R6: all requesting, prio 4 -> level 7 chosen
    cpuPrio = 3'd4;
    edges(4);
    cpuAck = 1'b1;
    edges(1); look();
    chk(ackLines == 4'b1000, "R6 ackLines level7", ackLines, 8);
    chk(svcLevel == 3'd7, "R6 svcLevel", svcLevel, 7);

    // R7: hold despite changes
    @(posedge clk); #1;
    reqLinesN = 4'b1110; cpuPrio = 3'd0; irqEnable = 1'b0;
    edges(5); look();
    chk(ackLines == 4'b1000, "R7 ackLines held", ackLines, 8);
    chk(svcLevel == 3'd7, "R7 svcLevel held", svcLevel, 7);

    // R8: release
    @(posedge clk); #1;
    cpuAck = 1'b0;
    edges(1); look();
    chk(ackLines == 4'b0, "R8 ackLines cleared", ackLines, 0);
    chk(svcLevel == 3'd0, "R8 svcLevel cleared", svcLevel, 0);

    // R9: ack with nothing eligible
    @(posedge clk); #1;
    irqEnable = 1'b1; reqLinesN = 4'b1110; cpuPrio = 3'd4;
    edges(4);
    cpuAck = 1'b1;
    edges(1); look();
    chk(ackLines == 4'b0, "R9 no line", ackLines, 0);
    chk(svcLevel == 3'd0, "R9 no level", svcLevel, 0);
    @(posedge clk); #1;
    reqLinesN = 4'b0000; cpuPrio = 3'd0;
    edges(4); look();
    chk(ackLines == 4'b0, "R9 stays empty during ack", ackLines, 0);
    @(posedge clk); #1;
    cpuAck = 1'b0;
    edges(2);

    // random phase
    for (int it = 0; it < 400; it++) begin
      r = 4'($urandom);
      p = 3'($urandom);
      e = ($urandom % 8) != 0;
      reqLinesN = r; cpuPrio = p; irqEnable = e;
      edges(4); look();
      lvl = expLevel(r, p, e);
      chk(intReq == (lvl != 0), "R3 R4 random intReq", intReq, int'(lvl != 0));
      if ($urandom % 2 == 1) begin
        @(posedge clk); #1;
        cpuAck = 1'b1;
        edges(1); look();
        chk(ackLines == expAck(lvl), "R6 random ackLines", ackLines, expAck(lvl));
        chk(int'(svcLevel) == lvl, "R6 random svcLevel", svcLevel, lvl);
        chk($countones(ackLines) <= 1, "R10 one line", $countones(ackLines), 1);
        heldAck = ackLines; heldLvl = svcLevel;
        @(posedge clk); #1;
        reqLinesN = 4'($urandom); cpuPrio = 3'($urandom); irqEnable = 1'($urandom);
        edges(4); look();
        chk(ackLines == heldAck, "R7 random hold", ackLines, heldAck);
        chk(svcLevel == heldLvl, "R7 random level hold", svcLevel, heldLvl);
        @(posedge clk); #1;
        cpuAck = 1'b0;
        edges(1); look();
        chk(ackLines == 4'b0 && svcLevel == 3'd0, "R8 random release", ackLines, 0);
      end
      @(posedge clk); #1;
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule